// File: doc/BRIEF.md
# GPIO Pad Register Bank

This block is the register file that sits between a 32-bit register bus and a bank of general-purpose pins. The pin count is a parameter and defaults to 95. The address space holds two kinds of register:

- **Bitmap words.** Each word carries one bit for each of 32 pins. There are four such families: pin ownership, interrupt routing, interrupt status and interrupt enable. One global control word sits beside them.
- **Per-pin configuration words.** Each pin has a pair of words placed at a fixed stride. The first word holds the output level, direction, function select and trigger mode. The second holds the pull code and the input-sense gate.

The bank drives the per-pin controls straight to the pad ring. It presents the synchronised, sense-gated input level to a separate interrupt detection block. That detection block pulses `irq_set` back into the status bitmap.

Register access uses a valid/ready request channel and a valid/ready response channel. Only one response is held at a time:

- A request is accepted in a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high when no response is pending, or when the pending response is being taken in the same cycle.
- The response for an accepted request appears in the next cycle. It stays valid, with stable data, until `rsp_ready` is seen.
- Writes also return a response, with data 0.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, every first configuration word reads 0x00000005 (input direction, function 1 = GPIO). Every second configuration word reads 0x00000004 (sensing disabled, pull 0 = none). All bitmaps and the global word read 0. `pad_oe` is all 0 and `sense_level` is all 0.
- R2: First configuration word fields:
  - Bit 31 drives `pad_out`.
  - Bit 4 drives `trig_level` (0 edge, 1 level).
  - Bit 3 drives `trig_invert`.
  - Bit 2 is the direction (1 input, 0 output); `pad_oe` is its inverse.
  - Bits 1:0 drive the pin's two-bit slice of `pad_fsel` (0 native, 1 GPIO).
  - All other bits read 0.
- R3: Bit 30 of the first configuration word is read-only. It shows the pin's input after a two-flop synchroniser, so it follows `pad_in` two clock edges later. Writes to bit 30 are ignored.
- R4: Bit 2 of the second configuration word, when 1, disables input sensing. The pin's bit 30 then reads 0 and its `sense_level` is 0. Bits 1:0 are the pull code (0 none, 1 down, 2 up) exported on `pad_pull`.
- R5: Pin p's first configuration word is at byte offset 0x100 + 8p. Its second configuration word is at 0x104 + 8p.
- R6: Pin p's bit in a bitmap family is bit p mod 32 of the word at the family base + 4*(p/32). The family bases are:
  - ownership at 0x00 (a bit of 0 means the pin is reserved for firmware);
  - routing at 0x10;
  - status at 0x80;
  - enable at 0x90.

  Bits for pins at or above the pin count read 0 and are not writable.
- R7: The word at 0x7C is a 32-bit read/write global control word, exported on `glob_ctrl`.
- R8: Interrupt status handling:
  - An `irq_set` pulse sets the pin's status bit.
  - Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
  - If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Unmapped accesses read 0, and writes to them change nothing. Unmapped means any of:
  - offsets not assigned to a register;
  - offsets that are not a multiple of 4;
  - configuration slots of pins at or above the pin count.
- R10: A request is taken when `req_valid && req_ready`. `rsp_valid` rises in the next cycle. While `rsp_valid && !rsp_ready`, the response and its data are held and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| pad_in | input | NUM_PINS | Raw pin input levels |
| pad_out | output | NUM_PINS | Output level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin (1 drive) |
| pad_fsel | output | 2*NUM_PINS | Function select, two bits per pin |
| pad_pull | output | 2*NUM_PINS | Pull code, two bits per pin |
| trig_level | output | NUM_PINS | Trigger mode per pin (1 level) |
| trig_invert | output | NUM_PINS | Trigger inversion per pin |
| sense_level | output | NUM_PINS | Synchronised, sense-gated input to interrupt detection |
| irq_set | input | NUM_PINS | Status set pulses from interrupt detection |
| irq_enable | output | NUM_PINS | Interrupt enable bitmap |
| irq_route | output | NUM_PINS | Interrupt routing bitmap |
| irq_status | output | NUM_PINS | Interrupt status bitmap |
| pin_host_owned | output | NUM_PINS | Ownership bitmap (0 reserved for firmware) |
| glob_ctrl | output | 32 | Global control word |

## Verification
The bench builds the bank with the default 95 pins and a 12-bit offset. With these values the last bitmap word is only partly populated: pins 64 to 94 fill 31 bits, and bit 31 maps to no pin. The configuration slot just after pin 94, at offsets 0x3F8 and 0x3FC, is reachable but belongs to no pin. This makes both the masking of the unused bitmap bit and the rejection of a configuration slot past the last pin observable. A 12-bit offset also reaches every bitmap base and the whole configuration range, so the decoder's handling of gaps and misaligned offsets can be driven at the ports.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  // Byte offsets decoded by software; their values are part of the map.
  localparam int OFS_OWN    = 'h000;
  localparam int OFS_ROUTE  = 'h010;
  localparam int OFS_GLOB   = 'h07C;
  localparam int OFS_STAT   = 'h080;
  localparam int OFS_EN     = 'h090;
  localparam int OFS_CFG    = 'h100;
  localparam int CFG_SHIFT  = 3;     // 8-byte stride per pin

  // First configuration word bit positions
  localparam int B1_OUT  = 31;
  localparam int B1_IN   = 30;
  localparam int B1_TRIG = 4;
  localparam int B1_INV  = 3;
  localparam int B1_DIR  = 2;

  // Second configuration word bit positions
  localparam int B2_DIS  = 2;

  typedef struct packed {
    logic       out_lvl;
    logic       trig_lvl;
    logic       trig_inv;
    logic       dir_in;
    logic [1:0] fsel;
    logic       sense_dis;
    logic [1:0] pull;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{
    out_lvl:   1'b0,
    trig_lvl:  1'b0,
    trig_inv:  1'b0,
    dir_in:    1'b1,
    fsel:      2'd1,
    sense_dis: 1'b1,
    pull:      2'd0
  };

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpb_pin_cfg.sv
module gpb_pin_cfg
  import gpb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cfg1,
  input  logic        wr_cfg2,
  input  logic [31:0] wdata,
  input  logic        sync_in,
  output pin_cfg_t    cfg,
  output logic        sense_level,
  output logic [31:0] rd_cfg1,
  output logic [31:0] rd_cfg2
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[30:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else begin
      if (wr_cfg1) begin
        cfg.out_lvl  <= wdata[B1_OUT];
        cfg.trig_lvl <= wdata[B1_TRIG];
        cfg.trig_inv <= wdata[B1_INV];
        cfg.dir_in   <= wdata[B1_DIR];
        cfg.fsel     <= wdata[1:0];
      end
      if (wr_cfg2) begin
        cfg.sense_dis <= wdata[B2_DIS];
        cfg.pull      <= wdata[1:0];
      end
    end
  end

  assign sense_level = sync_in & ~cfg.sense_dis;

  assign rd_cfg1 = {cfg.out_lvl, sense_level, 25'd0, cfg.trig_lvl,
                    cfg.trig_inv, cfg.dir_in, cfg.fsel};
  assign rd_cfg2 = {29'd0, cfg.sense_dis, cfg.pull};

  AST_CFG1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg1 |=> $stable({cfg.out_lvl, cfg.trig_lvl, cfg.trig_inv, cfg.dir_in, cfg.fsel})); // R2

  AST_CFG2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg2 |=> $stable({cfg.sense_dis, cfg.pull})); // R4
endmodule

// File: rtl/gpb_bitmap_regs.sv
module gpb_bitmap_regs #(
  parameter int N  = 95,
  parameter int NW = (N + 31) / 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_own,
  input  logic [NW-1:0]    wr_route,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW-1:0]    wr_clr,
  input  logic             wr_glob,
  input  logic [31:0]      wdata,
  input  logic [N-1:0]     irq_set,
  output logic [NW*32-1:0] own_v,
  output logic [NW*32-1:0] route_v,
  output logic [NW*32-1:0] en_v,
  output logic [NW*32-1:0] stat_v,
  output logic [31:0]      glob_q
);
  localparam int PW = NW * 32;

  logic [PW-1:0] set_pad;
  assign set_pad = PW'(irq_set);

  logic [31:0] own_w   [NW];
  logic [31:0] route_w [NW];
  logic [31:0] en_w    [NW];
  logic [31:0] stat_w  [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int VB = ((N - w * 32) >= 32) ? 32 : (N - w * 32);
    localparam logic [31:0] MASK = (VB == 32) ? 32'hFFFF_FFFF : ((32'd1 << VB) - 32'd1);
    logic [31:0] set_w;
    assign set_w = set_pad[w*32 +: 32] & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_w[w]   <= '0;
        route_w[w] <= '0;
        en_w[w]    <= '0;
        stat_w[w]  <= '0;
      end else begin
        if (wr_own[w])   own_w[w]   <= wdata & MASK;
        if (wr_route[w]) route_w[w] <= wdata & MASK;
        if (wr_en[w])    en_w[w]    <= wdata & MASK;
        stat_w[w] <= (stat_w[w] & ~(wr_clr[w] ? wdata : 32'd0)) | set_w;
      end
    end

    assign own_v[w*32 +: 32]   = own_w[w];
    assign route_v[w*32 +: 32] = route_w[w];
    assign en_v[w*32 +: 32]    = en_w[w];
    assign stat_v[w*32 +: 32]  = stat_w[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       glob_q <= '0;
    else if (wr_glob) glob_q <= wdata;
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr == '0) |=> ((stat_v & $past(stat_v)) == $past(stat_v))); // R8

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(en_v)); // R6
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [2*NUM_PINS-1:0] pad_fsel,
  output logic [2*NUM_PINS-1:0] pad_pull,
  output logic [NUM_PINS-1:0]   trig_level,
  output logic [NUM_PINS-1:0]   trig_invert,
  output logic [NUM_PINS-1:0]   sense_level,
  input  logic [NUM_PINS-1:0]   irq_set,
  output logic [NUM_PINS-1:0]   irq_enable,
  output logic [NUM_PINS-1:0]   irq_route,
  output logic [NUM_PINS-1:0]   irq_status,
  output logic [NUM_PINS-1:0]   pin_host_owned,
  output logic [31:0]           glob_ctrl
);
  localparam int N    = NUM_PINS;
  localparam int NW   = (N + 31) / 32;
  localparam int WA_W = ADDR_W - 2;
  localparam int CP_W = ADDR_W - CFG_SHIFT;

  // ---------------- handshake ----------------
  logic acc, wr_acc;
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;

  // ---------------- decode ----------------
  logic            aligned;
  logic [WA_W-1:0] wa;
  logic [CP_W-1:0] cfg_slot, cfg_pin;
  logic            cfg_hit;

  assign aligned  = (req_addr[1:0] == 2'b00);
  assign wa       = req_addr[ADDR_W-1:2];
  assign cfg_slot = req_addr[ADDR_W-1:CFG_SHIFT];
  assign cfg_pin  = cfg_slot - CP_W'(OFS_CFG >> CFG_SHIFT);
  assign cfg_hit  = aligned && (cfg_slot >= CP_W'(OFS_CFG >> CFG_SHIFT)) &&
                    (cfg_pin < CP_W'(N));

  logic [NW-1:0] hit_own, hit_route, hit_stat, hit_en;
  logic          hit_glob;

  for (genvar w = 0; w < NW; w++) begin : g_hit
    assign hit_own[w]   = aligned && (wa == WA_W'(OFS_OWN   / 4 + w));
    assign hit_route[w] = aligned && (wa == WA_W'(OFS_ROUTE / 4 + w));
    assign hit_stat[w]  = aligned && (wa == WA_W'(OFS_STAT  / 4 + w));
    assign hit_en[w]    = aligned && (wa == WA_W'(OFS_EN    / 4 + w));
  end
  assign hit_glob = aligned && (wa == WA_W'(OFS_GLOB / 4));

  // ---------------- per-pin configuration ----------------
  logic [N-1:0] wr1, wr2, pad_sync;
  logic [31:0]  rd1 [N];
  logic [31:0]  rd2 [N];
  pin_cfg_t     cfg_q [N];

  gpb_sync #(.W(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  for (genvar p = 0; p < N; p++) begin : g_pin
    assign wr1[p] = wr_acc && cfg_hit && (cfg_pin == CP_W'(p)) && !req_addr[2];
    assign wr2[p] = wr_acc && cfg_hit && (cfg_pin == CP_W'(p)) &&  req_addr[2];

    gpb_pin_cfg u_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_cfg1     (wr1[p]),
      .wr_cfg2     (wr2[p]),
      .wdata       (req_wdata),
      .sync_in     (pad_sync[p]),
      .cfg         (cfg_q[p]),
      .sense_level (sense_level[p]),
      .rd_cfg1     (rd1[p]),
      .rd_cfg2     (rd2[p])
    );

    assign pad_out[p]         = cfg_q[p].out_lvl;
    assign pad_oe[p]          = ~cfg_q[p].dir_in;
    assign pad_fsel[2*p +: 2] = cfg_q[p].fsel;
    assign pad_pull[2*p +: 2] = cfg_q[p].pull;
    assign trig_level[p]      = cfg_q[p].trig_lvl;
    assign trig_invert[p]     = cfg_q[p].trig_inv;
  end

  // ---------------- bitmap words ----------------
  logic [NW*32-1:0] own_v, route_v, en_v, stat_v;

  gpb_bitmap_regs #(.N(N), .NW(NW)) u_bmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_own   (hit_own   & {NW{wr_acc}}),
    .wr_route (hit_route & {NW{wr_acc}}),
    .wr_en    (hit_en    & {NW{wr_acc}}),
    .wr_clr   (hit_stat  & {NW{wr_acc}}),
    .wr_glob  (hit_glob && wr_acc),
    .wdata    (req_wdata),
    .irq_set  (irq_set),
    .own_v    (own_v),
    .route_v  (route_v),
    .en_v     (en_v),
    .stat_v   (stat_v),
    .glob_q   (glob_ctrl)
  );

  assign pin_host_owned = own_v[N-1:0];
  assign irq_route      = route_v[N-1:0];
  assign irq_enable     = en_v[N-1:0];
  assign irq_status     = stat_v[N-1:0];

  // ---------------- read mux ----------------
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++) begin
      if (hit_own[w])   rd_mux = own_v[w*32 +: 32];
      if (hit_route[w]) rd_mux = route_v[w*32 +: 32];
      if (hit_stat[w])  rd_mux = stat_v[w*32 +: 32];
      if (hit_en[w])    rd_mux = en_v[w*32 +: 32];
    end
    if (hit_glob) rd_mux = glob_ctrl;
    for (int p = 0; p < N; p++) begin
      if (cfg_hit && (cfg_pin == CP_W'(p)))
        rd_mux = req_addr[2] ? rd2[p] : rd1[p];
    end
  end

  // ---------------- response ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'd0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10

  AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
endmodule

// File: tb/test_gpio_pad_bank.sv
`timescale 1ns/1ps
module test_gpio_pad_bank;
  localparam int N  = 95;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            req_ready, rsp_valid;
  logic [31:0]     rsp_rdata;
  logic [N-1:0]    pad_in = '0, irq_set = '0;
  logic [N-1:0]    pad_out, pad_oe, trig_level, trig_invert, sense_level;
  logic [N-1:0]    irq_enable, irq_route, irq_status, pin_host_owned;
  logic [2*N-1:0]  pad_fsel, pad_pull;
  logic [31:0]     glob_ctrl;

  gpio_pad_bank #(.NUM_PINS(N), .ADDR_W(AW)) i_gpio_pad_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_fsel(pad_fsel), .pad_pull(pad_pull),
    .trig_level(trig_level), .trig_invert(trig_invert), .sense_level(sense_level),
    .irq_set(irq_set), .irq_enable(irq_enable), .irq_route(irq_route),
    .irq_status(irq_status), .pin_host_owned(pin_host_owned), .glob_ctrl(glob_ctrl)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                      output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h100, 32'h0,         32'h0000_0005},  // R1 cfg1 reset
    '{1'b0, 12'h104, 32'h0,         32'h0000_0004},  // R1 cfg2 reset
    '{1'b1, 12'h100, 32'hC000_011A, 32'h8000_001A},  // R2 R3 fields, bit30 ignored
    '{1'b1, 12'h244, 32'h0000_0002, 32'h0000_0002},  // R4 R5 pin40 pull-up, sensing on
    '{1'b1, 12'h3F0, 32'h8000_0001, 32'h8000_0001},  // R5 pin94 cfg1
    '{1'b1, 12'h3F8, 32'hFFFF_FFFF, 32'h0},          // R9 pin95 slot
    '{1'b1, 12'h3FC, 32'hFFFF_FFFF, 32'h0},          // R9 pin95 slot
    '{1'b1, 12'h07C, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R7 global word
    '{1'b1, 12'h040, 32'h0000_1234, 32'h0},          // R9 gap
    '{1'b1, 12'h07E, 32'hFFFF_FFFF, 32'h0},          // R9 misaligned
    '{1'b1, 12'h098, 32'hFFFF_FFFF, 32'h7FFF_FFFF},  // R6 partial last word
    '{1'b1, 12'h094, 32'h0000_0100, 32'h0000_0100},  // R6 enable pin40
    '{1'b1, 12'h014, 32'h0000_0001, 32'h0000_0001},  // R6 route pin32
    '{1'b1, 12'h008, 32'h8000_0001, 32'h0000_0001},  // R6 ownership pin64
    '{1'b0, 12'h080, 32'h0,         32'h0},          // R8 status clear
    '{1'b1, 12'h10C, 32'h0000_0001, 32'h0000_0001}   // R4 R5 pin1 pull-down
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R1)
    chk("R1 pad_oe", 32'(pad_oe != '0), 32'd0);
    chk("R1 sense_level", 32'(sense_level != '0), 32'd0);
    chk("R1 pad_fsel", 32'(pad_fsel == {N{2'b01}}), 32'd1);
    chk("R1 irq_status", 32'(irq_status != '0), 32'd0);
    chk("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 idle req_ready", 32'(req_ready), 32'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) xfer(1'b1, VECS[i].addr, VECS[i].data, r);
      xfer(1'b0, VECS[i].addr, 32'h0, r);
      chk($sformatf("vector %0d addr %03h", i, VECS[i].addr), r, VECS[i].exp);
    end

    // Port effects of the writes above
    chk("R2 pad_out[0]", 32'(pad_out[0]), 32'd1);
    chk("R2 pad_oe[0]", 32'(pad_oe[0]), 32'd1);
    chk("R2 trig_level[0]", 32'(trig_level[0]), 32'd1);
    chk("R2 trig_invert[0]", 32'(trig_invert[0]), 32'd1);
    chk("R2 pad_fsel pin0", 32'(pad_fsel[1:0]), 32'd2);
    chk("R2 pad_fsel pin94", 32'(pad_fsel[189:188]), 32'd1);
    chk("R2 pad_oe[94]", 32'(pad_oe[94]), 32'd1);
    chk("R4 pad_pull pin40", 32'(pad_pull[81:80]), 32'd2);
    chk("R4 pad_pull pin1", 32'(pad_pull[3:2]), 32'd1);
    chk("R6 irq_enable[40]", 32'(irq_enable[40]), 32'd1);
    chk("R6 irq_enable[94]", 32'(irq_enable[94]), 32'd1);
    chk("R6 irq_enable[63]", 32'(irq_enable[63]), 32'd0);
    chk("R6 irq_route[32]", 32'(irq_route[32]), 32'd1);
    chk("R6 pin_host_owned[64]", 32'(pin_host_owned[64]), 32'd1);
    chk("R6 pin_host_owned[94]", 32'(pin_host_owned[94]), 32'd0);
    chk("R7 glob_ctrl", glob_ctrl, 32'hA5A5_0F0F);

    // Input synchroniser and sense gate (R3, R4)
    @(negedge clk); pad_in[40] = 1'b1; pad_in[41] = 1'b1;
    @(negedge clk);
    chk("R3 one edge after input", 32'(sense_level[40]), 32'd0);
    @(negedge clk);
    chk("R3 two edges after input", 32'(sense_level[40]), 32'd1);
    chk("R4 pin41 sensing disabled", 32'(sense_level[41]), 32'd0);
    xfer(1'b0, 12'h240, 32'h0, r);
    chk("R3 input bit reads back", r, 32'h4000_0005);
    xfer(1'b1, 12'h240, 32'h0000_0005, r);
    xfer(1'b0, 12'h240, 32'h0, r);
    chk("R3 write of 0 to bit30 ignored", r, 32'h4000_0005);
    xfer(1'b0, 12'h248, 32'h0, r);
    chk("R4 pin41 bit30 gated", r, 32'h0000_0005);
    xfer(1'b1, 12'h244, 32'h0000_0004, r);
    xfer(1'b0, 12'h240, 32'h0, r);
    chk("R4 gated after disable", r, 32'h0000_0005);
    chk("R4 sense_level after disable", 32'(sense_level[40]), 32'd0);
    chk("R4 pad_pull pin40 none", 32'(pad_pull[81:80]), 32'd0);

    // Interrupt status (R8)
    irq_set[70] = 1'b1;
    @(negedge clk); irq_set[70] = 1'b0;
    xfer(1'b0, 12'h088, 32'h0, r);
    chk("R8 set by pulse", r, 32'h0000_0040);
    chk("R8 irq_status[70]", 32'(irq_status[70]), 32'd1);
    xfer(1'b1, 12'h088, 32'h0, r);
    xfer(1'b0, 12'h088, 32'h0, r);
    chk("R8 write 0 keeps bit", r, 32'h0000_0040);
    xfer(1'b1, 12'h088, 32'h0000_0040, r);
    xfer(1'b0, 12'h088, 32'h0, r);
    chk("R8 write 1 clears", r, 32'h0);
    irq_set[70] = 1'b1;
    xfer(1'b1, 12'h088, 32'h0000_0040, r);
    irq_set[70] = 1'b0;
    xfer(1'b0, 12'h088, 32'h0, r);
    chk("R8 set wins over clear", r, 32'h0000_0040);
    xfer(1'b1, 12'h088, 32'h0000_0040, r);
    xfer(1'b0, 12'h088, 32'h0, r);
    chk("R8 cleared again", r, 32'h0);

    // Back-pressure (R10)
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h07C;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_wdata = 32'h0;
    chk("R10 response valid", 32'(rsp_valid), 32'd1);
    chk("R10 stalled req_ready", 32'(req_ready), 32'd0);
    chk("R10 stalled data", rsp_rdata, 32'hA5A5_0F0F);
    repeat (3) @(negedge clk);
    chk("R10 held valid", 32'(rsp_valid), 32'd1);
    chk("R10 held data", rsp_rdata, 32'hA5A5_0F0F);
    chk("R10 write not taken while stalled", glob_ctrl, 32'hA5A5_0F0F);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 write response", 32'(rsp_valid), 32'd1);
    chk("R10 write response data", rsp_rdata, 32'h0);
    xfer(1'b0, 12'h07C, 32'h0, r);
    chk("R10 write taken once", r, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule